// File: doc/BRIEF.md
# Capture Pixel Format Packer

This block sits behind a video capture front end and turns one incoming pixel per clock into one memory word in the storage format chosen by a handful of control bits. The pixel arrives either as luma/chroma from a digital video port or as three separate red, green and blue components. A source-select input picks between them, and RGB components are converted to YCbCr on entry. The block can then store the pixel as 16 bpp YCbCr with alternating chroma, or convert it to RGB and pack it as a 16 or 24 bpp word with the components in alpha-first or alpha-last order.

Every RGB word carries a one-bit blend flag copied from a control input. It sits at the most significant used bit for alpha-first ordering and at bit 0 for alpha-last ordering. The pipeline always accepts input once reset is released, and it delivers each word exactly three cycles after the pixel is accepted. The control bits are sampled together with each pixel, so the format may change from one pixel to the next. Frame addressing, scaling and display are handled elsewhere.

Top module: `cpk_capture_packer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `word_valid` is 0 and `word_data` is 0. `pix_ready` is 0 during reset and 1 from the first clock edge after reset is released.
- R2: A pixel is accepted on a clock edge where `pix_valid` and `pix_ready` are both 1. Its word appears with `word_valid`=1 exactly three cycles after acceptance. `word_valid` is 1 in no other cycle, and back-to-back pixels give back-to-back words.
- R3: With `cfg_store_rgb`=0 the word is `{16'b0, Y[7:0], C[7:0]}`, where C is Cb or Cr as chosen by the chroma phase.
- R4: The chroma phase is Cb for the first pixel accepted after reset and toggles on every accepted pixel, whatever the format.
- R5: With `src_rgb`=1, Y = (77R+150G+29B+128)>>8, Cb = ((-43R-85G+128B+128)>>8)+128 and Cr = ((128R-107G-21B+128)>>8)+128. Each shift is an arithmetic (floor) shift and each result is clamped to 0..255. With `src_rgb`=0, the `vid_*` inputs are used unchanged.
- R6: With `cfg_store_rgb`=1, and with d_b=Cb-128 and d_r=Cr-128: R = Y+((359·d_r+128)>>8), G = Y+((-88·d_b-183·d_r+128)>>8) and B = Y+((454·d_b+128)>>8). Each result uses the same floor shift and is clamped to 0..255.
- R7: RGB, 16 bpp, alpha-first (`cfg_wide`=0, `cfg_rgba`=0): the word is `{16'b0, blend, R[7:3], G[7:3], B[7:3]}`.
- R8: RGB, 16 bpp, alpha-last (`cfg_rgba`=1): the word is `{16'b0, R[7:3], G[7:3], B[7:3], blend}`.
- R9: RGB, 24 bpp, alpha-first (`cfg_wide`=1): the word is `{blend, 7'b0, R, G, B}`.
- R10: RGB, 24 bpp, alpha-last: the word is `{R, G, B, 7'b0, blend}`.
- R11: All control inputs are sampled in the cycle the pixel is accepted. A change between two consecutive pixels affects only the later one.
- R12: Cycles with `pix_valid`=0 produce no word and leave the chroma phase unchanged, whatever the data and control inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Input pixel present |
| pix_ready | output | 1 | Block can accept a pixel |
| src_rgb | input | 1 | 0: video-port YCbCr, 1: separate RGB inputs |
| vid_y | input | 8 | Video-port luma |
| vid_cb | input | 8 | Video-port blue-difference chroma |
| vid_cr | input | 8 | Video-port red-difference chroma |
| rgb_r | input | 8 | Red component |
| rgb_g | input | 8 | Green component |
| rgb_b | input | 8 | Blue component |
| cfg_store_rgb | input | 1 | Store as RGB (1) or YCbCr (0) |
| cfg_wide | input | 1 | 24 bpp (1) or 16 bpp (0) RGB storage |
| cfg_rgba | input | 1 | Alpha-last (1) or alpha-first (0) ordering |
| cfg_blend | input | 1 | Blend flag written into RGB words |
| word_valid | output | 1 | Output word present |
| word_data | output | 32 | Packed memory word |

## Verification
The hardest case to reach is a change of format, source and blend flag between two adjacent pixels while the pipeline is full. Only that case shows whether every stage carries the control bits of its own pixel instead of the current inputs. A directed burst therefore drives four pixels on consecutive cycles, each with a different source, storage format and ordering. The bench then compares the four words that follow back to back. The clamp corners of the colour conversion are reached with full-scale and zero chroma paired with extreme luma. Idle cycles filled with junk data are placed between pixels to show that the chroma phase does not move.

// File: rtl/cpk_pkg.sv
package cpk_pkg;

   localparam int CPK_FRAC = 8;

   // RGB -> YCbCr coefficients, scaled by 2**CPK_FRAC
   localparam int CPK_Y_R  = 77;
   localparam int CPK_Y_G  = 150;
   localparam int CPK_Y_B  = 29;
   localparam int CPK_CB_R = -43;
   localparam int CPK_CB_G = -85;
   localparam int CPK_CB_B = 128;
   localparam int CPK_CR_R = 128;
   localparam int CPK_CR_G = -107;
   localparam int CPK_CR_B = -21;

   // YCbCr -> RGB coefficients, scaled by 2**CPK_FRAC
   localparam int CPK_R_CR = 359;
   localparam int CPK_G_CB = -88;
   localparam int CPK_G_CR = -183;
   localparam int CPK_B_CB = 454;

   typedef struct packed {
      logic store_rgb;
      logic wide;
      logic rgba;
      logic blend;
      logic chroma_cr;
   } cpk_cfg_t;

   function automatic int cpk_clamp(input int v, input int maxv);
      if (v < 0)
         return 0;
      else if (v > maxv)
         return maxv;
      else
         return v;
   endfunction

endpackage

// File: rtl/cpk_rgb2ycc.sv
module cpk_rgb2ycc
   import cpk_pkg::*;
#(
   parameter int COMP_W    = 8,
   parameter bit RGB_IN_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_acc,
   input  logic              in_src_rgb,
   input  logic [COMP_W-1:0] in_y,
   input  logic [COMP_W-1:0] in_cb,
   input  logic [COMP_W-1:0] in_cr,
   input  logic [COMP_W-1:0] in_r,
   input  logic [COMP_W-1:0] in_g,
   input  logic [COMP_W-1:0] in_b,
   input  cpk_cfg_t          in_cfg,
   output logic              out_valid,
   output logic [COMP_W-1:0] out_y,
   output logic [COMP_W-1:0] out_cb,
   output logic [COMP_W-1:0] out_cr,
   output cpk_cfg_t          out_cfg
);

   localparam int MAXV = (1 << COMP_W) - 1;
   localparam int BIAS = 1 << (COMP_W - 1);
   localparam int HALF = 1 << (CPK_FRAC - 1);

   logic              take_rgb;
   logic [COMP_W-1:0] cv_y, cv_cb, cv_cr;

   generate
      if (RGB_IN_EN) begin : g_rgb_in
         assign take_rgb = in_src_rgb;
      end else begin : g_no_rgb_in
         assign take_rgb = 1'b0;
      end
   endgenerate

   always_comb begin
      int ri, gi, bi, ty, tb, tr;
      ri = int'(in_r);
      gi = int'(in_g);
      bi = int'(in_b);
      ty = (CPK_Y_R * ri + CPK_Y_G * gi + CPK_Y_B * bi + HALF) >>> CPK_FRAC;
      tb = ((CPK_CB_R * ri + CPK_CB_G * gi + CPK_CB_B * bi + HALF) >>> CPK_FRAC) + BIAS;
      tr = ((CPK_CR_R * ri + CPK_CR_G * gi + CPK_CR_B * bi + HALF) >>> CPK_FRAC) + BIAS;
      cv_y  = COMP_W'(cpk_clamp(ty, MAXV));
      cv_cb = COMP_W'(cpk_clamp(tb, MAXV));
      cv_cr = COMP_W'(cpk_clamp(tr, MAXV));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_y     <= '0;
         out_cb    <= '0;
         out_cr    <= '0;
         out_cfg   <= '0;
      end else begin
         out_valid <= in_acc;
         if (in_acc) begin
            out_y   <= take_rgb ? cv_y  : in_y;
            out_cb  <= take_rgb ? cv_cb : in_cb;
            out_cr  <= take_rgb ? cv_cr : in_cr;
            out_cfg <= in_cfg;
         end
      end
   end

endmodule

// File: rtl/cpk_ycc2rgb.sv
module cpk_ycc2rgb
   import cpk_pkg::*;
#(
   parameter int COMP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [COMP_W-1:0] in_y,
   input  logic [COMP_W-1:0] in_cb,
   input  logic [COMP_W-1:0] in_cr,
   input  cpk_cfg_t          in_cfg,
   output logic              out_valid,
   output logic [COMP_W-1:0] out_y,
   output logic [COMP_W-1:0] out_c,
   output logic [COMP_W-1:0] out_r,
   output logic [COMP_W-1:0] out_g,
   output logic [COMP_W-1:0] out_b,
   output cpk_cfg_t          out_cfg
);

   localparam int MAXV = (1 << COMP_W) - 1;
   localparam int BIAS = 1 << (COMP_W - 1);
   localparam int HALF = 1 << (CPK_FRAC - 1);

   logic [COMP_W-1:0] cv_r, cv_g, cv_b;

   always_comb begin
      int yi, db, dr;
      yi = int'(in_y);
      db = int'(in_cb) - BIAS;
      dr = int'(in_cr) - BIAS;
      cv_r = COMP_W'(cpk_clamp(yi + ((CPK_R_CR * dr + HALF) >>> CPK_FRAC), MAXV));
      cv_g = COMP_W'(cpk_clamp(yi + ((CPK_G_CB * db + CPK_G_CR * dr + HALF) >>> CPK_FRAC), MAXV));
      cv_b = COMP_W'(cpk_clamp(yi + ((CPK_B_CB * db + HALF) >>> CPK_FRAC), MAXV));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_y     <= '0;
         out_c     <= '0;
         out_r     <= '0;
         out_g     <= '0;
         out_b     <= '0;
         out_cfg   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_y   <= in_y;
            out_c   <= in_cfg.chroma_cr ? in_cr : in_cb;
            out_r   <= cv_r;
            out_g   <= cv_g;
            out_b   <= cv_b;
            out_cfg <= in_cfg;
         end
      end
   end

endmodule

// File: rtl/cpk_packer.sv
module cpk_packer
   import cpk_pkg::*;
#(
   parameter int COMP_W = 8,
   parameter int OUT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [COMP_W-1:0] in_y,
   input  logic [COMP_W-1:0] in_c,
   input  logic [COMP_W-1:0] in_r,
   input  logic [COMP_W-1:0] in_g,
   input  logic [COMP_W-1:0] in_b,
   input  cpk_cfg_t          in_cfg,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_word
);

   localparam int NARROW_C = 5;
   localparam int NARROW_W = 3 * NARROW_C + 1;
   localparam int PAD_W    = OUT_W - 3 * COMP_W - 1;
   localparam int YCC_W    = 2 * COMP_W;

   logic [COMP_W-1:0]   comp [3];
   logic [NARROW_C-1:0] comp5 [3];
   logic [OUT_W-1:0]    packed_w;

   assign comp[0] = in_r;
   assign comp[1] = in_g;
   assign comp[2] = in_b;

   generate
      for (genvar k = 0; k < 3; k++) begin : g_trunc
         assign comp5[k] = comp[k][COMP_W-1 -: NARROW_C];
      end
   endgenerate

   always_comb begin
      packed_w = '0;
      if (!in_cfg.store_rgb) begin
         packed_w[YCC_W-1:0] = {in_y, in_c};
      end else if (!in_cfg.wide) begin
         if (in_cfg.rgba)
            packed_w[NARROW_W-1:0] = {comp5[0], comp5[1], comp5[2], in_cfg.blend};
         else
            packed_w[NARROW_W-1:0] = {in_cfg.blend, comp5[0], comp5[1], comp5[2]};
      end else begin
         if (in_cfg.rgba)
            packed_w = {in_r, in_g, in_b, {PAD_W{1'b0}}, in_cfg.blend};
         else
            packed_w = {in_cfg.blend, {PAD_W{1'b0}}, in_r, in_g, in_b};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            out_word <= packed_w;
      end
   end

   // YCbCr words leave the upper half clear
   assert_ycc_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_cfg.store_rgb |=> out_word[OUT_W-1:YCC_W] == '0);

   // alpha-first 16 bpp: flag at bit 15, upper half clear
   assert_argb16_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_cfg.store_rgb && !in_cfg.wide && !in_cfg.rgba |=>
         out_word[NARROW_W-1] == $past(in_cfg.blend) && out_word[OUT_W-1:NARROW_W] == '0);

   // alpha-last: flag at bit 0 in both widths
   assert_rgba_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_cfg.store_rgb && in_cfg.rgba |=> out_word[0] == $past(in_cfg.blend));

   // alpha-first 24 bpp: flag at the top bit, padding clear
   assert_argb24_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_cfg.store_rgb && in_cfg.wide && !in_cfg.rgba |=>
         out_word[OUT_W-1] == $past(in_cfg.blend) && out_word[OUT_W-2 -: PAD_W] == '0);

endmodule

// File: rtl/cpk_capture_packer.sv
module cpk_capture_packer
   import cpk_pkg::*;
#(
   parameter int COMP_W    = 8,
   parameter int OUT_W     = 32,
   parameter bit RGB_IN_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_valid,
   output logic              pix_ready,
   input  logic              src_rgb,
   input  logic [COMP_W-1:0] vid_y,
   input  logic [COMP_W-1:0] vid_cb,
   input  logic [COMP_W-1:0] vid_cr,
   input  logic [COMP_W-1:0] rgb_r,
   input  logic [COMP_W-1:0] rgb_g,
   input  logic [COMP_W-1:0] rgb_b,
   input  logic              cfg_store_rgb,
   input  logic              cfg_wide,
   input  logic              cfg_rgba,
   input  logic              cfg_blend,
   output logic              word_valid,
   output logic [OUT_W-1:0]  word_data
);

   generate
      if (COMP_W < 5) begin : g_bad_comp_w
         initial $fatal(1, "COMP_W must be at least 5");
      end
      if (OUT_W < 3 * COMP_W + 2) begin : g_bad_out_w
         initial $fatal(1, "OUT_W too small for 24 bpp packing");
      end
   endgenerate

   logic     ready_q;
   logic     phase_q;
   logic     accept;
   cpk_cfg_t cfg_in;

   logic              s1_valid;
   logic [COMP_W-1:0] s1_y, s1_cb, s1_cr;
   cpk_cfg_t          s1_cfg;

   logic              s2_valid;
   logic [COMP_W-1:0] s2_y, s2_c, s2_r, s2_g, s2_b;
   cpk_cfg_t          s2_cfg;

   assign pix_ready = ready_q;
   assign accept    = pix_valid && ready_q;

   always_comb begin
      cfg_in.store_rgb = cfg_store_rgb;
      cfg_in.wide      = cfg_wide;
      cfg_in.rgba      = cfg_rgba;
      cfg_in.blend     = cfg_blend;
      cfg_in.chroma_cr = phase_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         phase_q <= 1'b0;
      end else begin
         ready_q <= 1'b1;
         if (accept)
            phase_q <= ~phase_q;
      end
   end

   cpk_rgb2ycc #(.COMP_W(COMP_W), .RGB_IN_EN(RGB_IN_EN)) i_rgb2ycc (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_acc    (accept),
      .in_src_rgb(src_rgb),
      .in_y      (vid_y),
      .in_cb     (vid_cb),
      .in_cr     (vid_cr),
      .in_r      (rgb_r),
      .in_g      (rgb_g),
      .in_b      (rgb_b),
      .in_cfg    (cfg_in),
      .out_valid (s1_valid),
      .out_y     (s1_y),
      .out_cb    (s1_cb),
      .out_cr    (s1_cr),
      .out_cfg   (s1_cfg)
   );

   cpk_ycc2rgb #(.COMP_W(COMP_W)) i_ycc2rgb (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (s1_valid),
      .in_y     (s1_y),
      .in_cb    (s1_cb),
      .in_cr    (s1_cr),
      .in_cfg   (s1_cfg),
      .out_valid(s2_valid),
      .out_y    (s2_y),
      .out_c    (s2_c),
      .out_r    (s2_r),
      .out_g    (s2_g),
      .out_b    (s2_b),
      .out_cfg  (s2_cfg)
   );

   cpk_packer #(.COMP_W(COMP_W), .OUT_W(OUT_W)) i_packer (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (s2_valid),
      .in_y     (s2_y),
      .in_c     (s2_c),
      .in_r     (s2_r),
      .in_g     (s2_g),
      .in_b     (s2_b),
      .in_cfg   (s2_cfg),
      .out_valid(word_valid),
      .out_word (word_data)
   );

   // every word traces back to an acceptance three edges earlier
   assert_word_has_pixel_R2: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> $past(accept, 3));

   // every acceptance yields a word three edges later
   assert_pixel_has_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(accept, 3) |-> word_valid);

   assert_phase_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> phase_q != $past(phase_q));

   assert_phase_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(phase_q));

endmodule

// File: tb/test_cpk_capture_packer.sv
`timescale 1ns/1ps
module test_cpk_capture_packer;

   typedef struct {
      bit       vld;
      bit       src;
      bit       store;
      bit       wide;
      bit       rgba;
      bit       blend;
      bit [7:0] y, cb, cr, r, g, b;
   } px_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_valid = 1'b0;
   logic        pix_ready;
   logic        src_rgb = 1'b0;
   logic [7:0]  vid_y = '0, vid_cb = '0, vid_cr = '0;
   logic [7:0]  rgb_r = '0, rgb_g = '0, rgb_b = '0;
   logic        cfg_store_rgb = 1'b0, cfg_wide = 1'b0, cfg_rgba = 1'b0, cfg_blend = 1'b0;
   logic        word_valid;
   logic [31:0] word_data;

   int checks = 0;
   int failures = 0;
   bit ph = 1'b0;
   px_t pq [8];

   always #5 clk = ~clk;

   cpk_capture_packer i_cpk_capture_packer (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
      .src_rgb(src_rgb), .vid_y(vid_y), .vid_cb(vid_cb), .vid_cr(vid_cr),
      .rgb_r(rgb_r), .rgb_g(rgb_g), .rgb_b(rgb_b),
      .cfg_store_rgb(cfg_store_rgb), .cfg_wide(cfg_wide), .cfg_rgba(cfg_rgba),
      .cfg_blend(cfg_blend), .word_valid(word_valid), .word_data(word_data)
   );

   function automatic int cl8(input int v);
      return (v < 0) ? 0 : ((v > 255) ? 255 : v);
   endfunction

   function automatic bit [31:0] model(input px_t p, input bit cr_phase);
      int y, cb, cr, r, g, b, db, dr;
      bit [7:0] r8, g8, b8;
      if (p.src) begin
         y  = cl8((77 * int'(p.r) + 150 * int'(p.g) + 29 * int'(p.b) + 128) >>> 8);
         cb = cl8(((-43 * int'(p.r) - 85 * int'(p.g) + 128 * int'(p.b) + 128) >>> 8) + 128);
         cr = cl8(((128 * int'(p.r) - 107 * int'(p.g) - 21 * int'(p.b) + 128) >>> 8) + 128);
      end else begin
         y = int'(p.y); cb = int'(p.cb); cr = int'(p.cr);
      end
      if (!p.store)
         return {16'h0, 8'(y), cr_phase ? 8'(cr) : 8'(cb)};
      db = cb - 128;
      dr = cr - 128;
      r = cl8(y + ((359 * dr + 128) >>> 8));
      g = cl8(y + ((-88 * db - 183 * dr + 128) >>> 8));
      b = cl8(y + ((454 * db + 128) >>> 8));
      r8 = 8'(r); g8 = 8'(g); b8 = 8'(b);
      if (!p.wide)
         return p.rgba ? {16'h0, r8[7:3], g8[7:3], b8[7:3], p.blend}
                       : {16'h0, p.blend, r8[7:3], g8[7:3], b8[7:3]};
      return p.rgba ? {r8, g8, b8, 7'h0, p.blend} : {p.blend, 7'h0, r8, g8, b8};
   endfunction

   function automatic px_t mk(input bit src, input bit store, input bit wide, input bit rgba,
                              input bit blend, input bit [7:0] a, input bit [7:0] bb,
                              input bit [7:0] c);
      px_t p;
      p.vld = 1'b1; p.src = src; p.store = store; p.wide = wide; p.rgba = rgba; p.blend = blend;
      p.y = a; p.cb = bb; p.cr = c; p.r = a; p.g = bb; p.b = c;
      return p;
   endfunction

   task automatic check(input string tag, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic drive(input px_t p, input bit junk);
      pix_valid     = p.vld;
      src_rgb       = junk ? ~p.src : p.src;
      cfg_store_rgb = junk ? ~p.store : p.store;
      cfg_wide      = junk ? ~p.wide : p.wide;
      cfg_rgba      = junk ? ~p.rgba : p.rgba;
      cfg_blend     = junk ? ~p.blend : p.blend;
      vid_y = junk ? 8'hA5 : p.y; vid_cb = junk ? 8'h5A : p.cb; vid_cr = junk ? 8'hC3 : p.cr;
      rgb_r = junk ? 8'h3C : p.r; rgb_g = junk ? 8'h96 : p.g; rgb_b = junk ? 8'h69 : p.b;
   endtask

   // drives pq[0..n-1] on consecutive cycles; words checked three cycles later
   task automatic run_burst(input int n, input string tag);
      bit [31:0] expw [8];
      bit        expv [8];
      for (int t = 0; t < n + 4; t++) begin
         @(negedge clk);
         if (t >= 3) begin
            check(tag, "word_valid", {31'h0, word_valid}, {31'h0, expv[t-3]});
            if (expv[t-3])
               check(tag, "word_data", word_data, expw[t-3]);
         end else if (t >= 1) begin
            check(tag, "word_valid idle", {31'h0, word_valid}, 32'h0);
         end
         if (t < n) begin
            drive(pq[t], !pq[t].vld);
            expv[t] = pq[t].vld;
            if (pq[t].vld) begin
               expw[t] = model(pq[t], ph);
               ph = ~ph;
            end
         end else begin
            pix_valid = 1'b0;
            if (t < 8) expv[t] = 1'b0;
         end
      end
      for (int k = n; k < 8; k++) expv[k] = 1'b0;
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", "pix_ready in reset", {31'h0, pix_ready}, 32'h0);
      check("R1", "word_valid in reset", {31'h0, word_valid}, 32'h0);
      check("R1", "word_data in reset", word_data, 32'h0);
      rst_n = 1'b1;
      ph = 1'b0;
      @(negedge clk);
      check("R1", "pix_ready after reset", {31'h0, pix_ready}, 32'h1);
      check("R1", "word_valid after reset", {31'h0, word_valid}, 32'h0);
   endtask

   task automatic t_ycc_native;
      pq[0] = mk(0, 0, 0, 0, 0, 8'h10, 8'h20, 8'h30);
      pq[1] = mk(0, 0, 0, 0, 1, 8'h40, 8'h50, 8'h60);
      pq[2] = mk(0, 0, 1, 1, 0, 8'hEB, 8'h80, 8'hF0);
      pq[3] = mk(0, 0, 0, 1, 1, 8'h00, 8'hFF, 8'h01);
      run_burst(4, "R3 R4");
      check("R4", "first pixel uses Cb", model(pq[0], 1'b0), 32'h0000_1020);
   endtask

   task automatic t_rgb_source;
      pq[0] = mk(1, 0, 0, 0, 0, 8'hFF, 8'hFF, 8'hFF);
      pq[1] = mk(1, 0, 0, 0, 0, 8'h00, 8'h00, 8'h00);
      pq[2] = mk(1, 0, 0, 0, 0, 8'hFF, 8'h00, 8'h00);
      pq[3] = mk(1, 0, 0, 0, 0, 8'h00, 8'h00, 8'hFF);
      pq[4] = mk(1, 1, 1, 0, 1, 8'h12, 8'hC8, 8'h7F);
      run_burst(5, "R5");
   endtask

   task automatic t_rgb_store;
      pq[0] = mk(0, 1, 1, 0, 0, 8'hFF, 8'h80, 8'hFF);
      pq[1] = mk(0, 1, 1, 0, 0, 8'h00, 8'h80, 8'h00);
      pq[2] = mk(0, 1, 1, 0, 0, 8'h80, 8'h80, 8'h80);
      pq[3] = mk(0, 1, 1, 0, 0, 8'h51, 8'h5A, 8'hF0);
      pq[4] = mk(0, 1, 1, 0, 0, 8'h10, 8'hFF, 8'h00);
      run_burst(5, "R6");
      check("R6", "grey converts exactly", model(pq[2], 1'b0), 32'h0080_8080);
   endtask

   task automatic t_layouts;
      pq[0] = mk(0, 1, 0, 0, 1, 8'h9C, 8'h6E, 8'hB4);
      pq[1] = mk(0, 1, 0, 1, 1, 8'h9C, 8'h6E, 8'hB4);
      pq[2] = mk(0, 1, 1, 0, 1, 8'h9C, 8'h6E, 8'hB4);
      pq[3] = mk(0, 1, 1, 1, 1, 8'h9C, 8'h6E, 8'hB4);
      run_burst(4, "R7 R8 R9 R10");
      pq[0] = mk(0, 1, 0, 0, 0, 8'hFF, 8'h80, 8'h80);
      pq[1] = mk(0, 1, 0, 1, 0, 8'hFF, 8'h80, 8'h80);
      pq[2] = mk(0, 1, 1, 0, 0, 8'hFF, 8'h80, 8'h80);
      pq[3] = mk(0, 1, 1, 1, 0, 8'hFF, 8'h80, 8'h80);
      run_burst(4, "R7 R8 R9 R10 blend0");
      check("R9", "white 24bpp alpha-first flag set", model(mk(0, 1, 1, 0, 1, 8'hFF, 8'h80, 8'h80), 1'b0),
            32'h80FF_FFFF);
   endtask

   task automatic t_stream;
      pq[0] = mk(1, 1, 0, 1, 1, 8'h20, 8'hE0, 8'h40);
      pq[1] = mk(0, 0, 1, 0, 0, 8'h33, 8'h44, 8'h55);
      pq[2] = mk(1, 1, 1, 0, 1, 8'hFF, 8'h10, 8'h10);
      pq[3] = mk(0, 1, 0, 0, 0, 8'hA0, 8'h20, 8'hD0);
      pq[4] = mk(0, 0, 0, 0, 1, 8'h66, 8'h77, 8'h88);
      run_burst(5, "R2 R11");
   endtask

   task automatic t_idle;
      pq[0] = mk(0, 0, 0, 0, 0, 8'h11, 8'h22, 8'h33);
      pq[1] = mk(0, 0, 0, 0, 0, 8'h00, 8'h00, 8'h00); pq[1].vld = 1'b0;
      pq[2] = pq[1];
      pq[3] = mk(0, 0, 0, 0, 0, 8'h44, 8'h55, 8'h66);
      pq[4] = pq[1];
      pq[5] = mk(0, 0, 0, 0, 0, 8'h77, 8'h88, 8'h99);
      run_burst(6, "R12");
   endtask

   initial begin
      t_reset();
      t_ycc_native();
      t_rgb_source();
      t_rgb_store();
      t_layouts();
      t_stream();
      t_idle();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule